// File: doc/BRIEF.md
# Serial Receive Status and Error-Interrupt Unit

This block sits behind the bit shifter of an asynchronous serial receiver. Each time a character has finished shifting in, the shifter raises a one-cycle completion strobe. With that strobe it presents three samples taken near the middle of every bit position of the frame: the start bit, the data bits, the parity slot and the stop bit. The unit takes a majority vote of the samples in each bit. It checks the stop bit and the parity, and it holds the voted character in a receive data register until software reads it. It keeps four sticky error flags: overrun, noise, framing and parity.

Each flag has its own interrupt enable. All enabled flags are merged into a single error interrupt request. Software clears the flags in two steps: it reads the status, then it reads the data register. When the chip's debug-break state is active, a clear-enable control decides whether these accesses may change the flags. With the control at 0, debug reads cannot change any flag. A clearing sequence that was started before the break still completes afterwards.

Frame layout on `frame_samples` (bit position k occupies bits [3k+2:3k]): position 0 is the start bit, positions 1..DATA_W hold the data bits with the least significant bit first, position DATA_W+1 is the parity slot, and position DATA_W+2 is the stop bit. Flag vector bit order is 0 = overrun, 1 = noise, 2 = framing, 3 = parity.

Top module: `uart_rx_err_unit`

## Requirements
- R1: A completion strobe that arrives while the data register is still full (and is not being emptied by a permitted data read in the same cycle) sets the overrun flag (bit 0). The old character is kept in `rx_data`. The new character is dropped, and its other errors are not recorded.
- R2: Each bit takes the majority value of its three samples, and `rx_data` holds the voted data bits. In an accepted character, any bit position whose three samples disagree sets the noise flag (bit 1).
- R3: An accepted character whose voted stop bit is 0 sets the framing flag (bit 2).
- R4: `parity_mode` selects the parity check: 1 = even (the data bits and the parity bit together hold an even number of ones), 2 = odd, 0 or 3 = none. A mismatch sets the parity flag (bit 3). With none selected, the parity slot is ignored: it never sets the parity flag or the noise flag.
- R5: `err_irq` is 1 exactly when some flag is set and its matching `err_en` bit is 1.
- R6: A status read arms the flags that are set at that moment. A later permitted data read clears the armed flags only. A data read with nothing armed leaves the flags unchanged.
- R7: If a flag's error event occurs between the status read and the data read, that flag is still set after the data read.
- R8: While `brk_active` is 1 and `brk_clr_en` is 0, status and data reads change neither the flags, the arming nor `rx_full`.
- R9: While `brk_active` is 1 and `brk_clr_en` is 1, the two-step sequence clears flags, and they stay clear after the break ends.
- R10: A status read made before a protected break keeps its arming through the break. The first permitted data read after the break then clears the armed flags.
- R11: An accepted character sets `rx_full`, and a permitted data read clears it. Reset clears `rx_full`, `rx_data`, all flags and the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe: a character has finished shifting in |
| frame_samples | input | 3*(DATA_W+3) | Three samples per bit position of the frame |
| parity_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| err_en | input | 4 | Per-flag interrupt enables |
| status_rd | input | 1 | One-cycle strobe: software reads the status |
| data_rd | input | 1 | One-cycle strobe: software reads the data register |
| brk_active | input | 1 | Debug-break state is active |
| brk_clr_en | input | 1 | Allow accesses during the break to clear status |
| rx_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Data register holds an unread character |
| err_flags | output | 4 | Sticky error flags: overrun, noise, framing, parity |
| err_irq | output | 1 | Error interrupt request |

## Verification
The assertions check on every cycle that a flag can fall only one cycle after a permitted data read, and that any error event leaves its flag set in the next cycle. They also check that a protected break freezes the flags and `rx_full`, that an overrun leaves the data register untouched, and that a stop bit sampled as 0 raises the framing flag. Only the bench scenarios can show the encoding-level results: the voted data under injected noise, the parity decisions for each mode, and the ordered clearing sequences. These sequences are arming followed by a new event, arming before a break, and clearing during a permissive break.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    localparam int NFLAG    = 4;
    localparam int NSAMP    = 3;
    localparam int F_OVR    = 0;
    localparam int F_NOISE  = 1;
    localparam int F_FRAME  = 2;
    localparam int F_PAR    = 3;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;

    // Bit order matches the flag vector: parity is the MSB, overrun the LSB.
    typedef struct packed {
        logic par;
        logic frm;
        logic noise;
        logic ovr;
    } err_vec_t;

    function automatic logic maj3(input logic [NSAMP-1:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic split3(input logic [NSAMP-1:0] s);
        return (s != '0) && (s != '1);
    endfunction

    function automatic logic parity_checked(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

endpackage

// File: rtl/rxe_voter.sv
module rxe_voter
    import rxe_pkg::*;
#(
    parameter int NBITS = 11
) (
    input  logic [NSAMP*NBITS-1:0] samples,
    input  logic [NBITS-1:0]       pos_used,
    output logic [NBITS-1:0]       voted,
    output logic                   noisy
);
    logic [NBITS-1:0] split;

    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        logic [NSAMP-1:0] trip;
        assign trip     = samples[NSAMP*k +: NSAMP];
        assign voted[k] = maj3(trip);
        assign split[k] = split3(trip) & pos_used[k];
    end

    assign noisy = |split;
endmodule

// File: rtl/rxe_frame_check.sv
module rxe_frame_check
    import rxe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W+2:0] bits,
    input  par_mode_e         mode,
    output logic [DATA_W-1:0] data,
    output logic              frm_err,
    output logic              par_err
);
    localparam int PAR_POS  = DATA_W + 1;
    localparam int STOP_POS = DATA_W + 2;

    logic ones_odd;

    assign data     = bits[DATA_W:1];
    assign ones_odd = ^{data, bits[PAR_POS]};
    assign frm_err  = ~bits[STOP_POS];

    always_comb begin
        unique case (mode)
            PAR_EVEN: par_err = ones_odd;
            PAR_ODD:  par_err = ~ones_odd;
            default:  par_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxe_data_reg.sv
module rxe_data_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] new_data,
    input  logic              data_rd_ok,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              accept,
    output logic              overrun
);
    logic room;

    assign room    = ~full | data_rd_ok;
    assign accept  = frame_valid & room;
    assign overrun = frame_valid & ~room;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            full    <= 1'b0;
        end else begin
            if (accept) begin
                rx_data <= new_data;
                full    <= 1'b1;
            end else if (data_rd_ok) begin
                full    <= 1'b0;
            end
        end
    end

    // R1: an overrunning character leaves the register and the full state alone
    p_overrun_keeps_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && full && !data_rd_ok) |=> ($stable(rx_data) && full));

    // R11: a permitted read with no new character empties the register
    p_read_empties_r11: assert property (@(posedge clk) disable iff (rst)
        (data_rd_ok && !frame_valid) |=> !full);
endmodule

// File: rtl/rxe_flag_reg.sv
module rxe_flag_reg
    import rxe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_vec_t evt,
    input  logic     status_rd_ok,
    input  logic     data_rd_ok,
    output err_vec_t flags
);
    logic [NFLAG-1:0] flag_q, arm_q, flag_d, arm_d, clr;

    always_comb begin
        clr    = data_rd_ok ? arm_q : '0;
        flag_d = (flag_q & ~clr) | evt;
        arm_d  = arm_q;
        if (data_rd_ok)   arm_d = '0;
        if (status_rd_ok) arm_d = flag_q & ~clr;
        arm_d  = arm_d & ~evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flags = err_vec_t'(flag_q);

    // R6: a flag falls only right after a permitted data read
    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        (|($past(flags) & ~flags)) |-> $past(data_rd_ok));

    // R7: an error event always leaves its flag set in the next cycle
    p_event_sticks_r7: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/uart_rx_err_unit.sv
module uart_rx_err_unit
    import rxe_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + 3,
    localparam int SAMP_W  = NSAMP * FRAME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [SAMP_W-1:0] frame_samples,
    input  logic [1:0]        parity_mode,
    input  logic [NFLAG-1:0]  err_en,
    input  logic              status_rd,
    input  logic              data_rd,
    input  logic              brk_active,
    input  logic              brk_clr_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic [NFLAG-1:0]  err_flags,
    output logic              err_irq
);
    localparam int PAR_POS = DATA_W + 1;

    par_mode_e         mode;
    logic [FRAME_W-1:0] pos_used, voted;
    logic              noisy, frm_err, par_err;
    logic [DATA_W-1:0] new_data;
    logic              access_ok, status_ok, data_ok;
    logic              accept, overrun;
    err_vec_t          evt, flags;

    assign mode      = par_mode_e'(parity_mode);
    assign access_ok = ~brk_active | brk_clr_en;
    assign status_ok = status_rd & access_ok;
    assign data_ok   = data_rd & access_ok;

    always_comb begin
        pos_used          = '1;
        pos_used[PAR_POS] = parity_checked(mode);
    end

    rxe_voter #(.NBITS(FRAME_W)) u_vote (
        .samples  (frame_samples),
        .pos_used (pos_used),
        .voted    (voted),
        .noisy    (noisy)
    );

    rxe_frame_check #(.DATA_W(DATA_W)) u_chk (
        .bits    (voted),
        .mode    (mode),
        .data    (new_data),
        .frm_err (frm_err),
        .par_err (par_err)
    );

    rxe_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .new_data    (new_data),
        .data_rd_ok  (data_ok),
        .rx_data     (rx_data),
        .full        (rx_full),
        .accept      (accept),
        .overrun     (overrun)
    );

    always_comb begin
        evt.ovr   = overrun;
        evt.noise = accept & noisy;
        evt.frm   = accept & frm_err;
        evt.par   = accept & par_err;
    end

    rxe_flag_reg u_flags (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .status_rd_ok (status_ok),
        .data_rd_ok   (data_ok),
        .flags        (flags)
    );

    assign err_flags = flags;
    assign err_irq   = |(flags & err_en);

    // R8: a protected break freezes the status while no character arrives
    p_break_guard_r8: assert property (@(posedge clk) disable iff (rst)
        (brk_active && !brk_clr_en && !frame_valid) |=>
            ($stable(err_flags) && $stable(rx_full)));

    // R4: with parity checking off, the parity flag cannot rise
    p_no_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !err_flags[F_PAR] && !parity_checked(mode)) |=>
            !err_flags[F_PAR]);

    // R3: a clean zero stop bit on an accepted character raises the framing flag
    p_stop_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !rx_full && frame_samples[SAMP_W-1 -: NSAMP] == 3'b000)
            |=> err_flags[F_FRAME]);
endmodule

// File: tb/sim_uart_rx_err_unit.sv
module sim_uart_rx_err_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int FW = DW + 3;
    localparam int SW = 3 * FW;
    localparam int NVEC = 8;

    // {data[8], mode[2], parity_flip[1], stop[1], noise_pos[4] (15 = none), expected flags[4]}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'hA5, 2'd1, 1'b0, 1'b1, 4'd15, 4'b0000},
        {8'h3C, 2'd2, 1'b1, 1'b1, 4'd15, 4'b1000},
        {8'h01, 2'd0, 1'b1, 1'b1, 4'd15, 4'b0000},
        {8'hFF, 2'd1, 1'b0, 1'b0, 4'd15, 4'b0100},
        {8'h55, 2'd2, 1'b0, 1'b1, 4'd3,  4'b0010},
        {8'h80, 2'd1, 1'b1, 1'b0, 4'd0,  4'b1110},
        {8'h00, 2'd0, 1'b0, 1'b1, 4'd10, 4'b0010},
        {8'h7E, 2'd0, 1'b0, 1'b1, 4'd9,  4'b0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_valid = 1'b0;
    logic [SW-1:0] frame_samples = '0;
    logic [1:0]    parity_mode = 2'd0;
    logic [3:0]    err_en = 4'hF;
    logic          status_rd = 1'b0, data_rd = 1'b0;
    logic          brk_active = 1'b0, brk_clr_en = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_full;
    logic [3:0]    err_flags;
    logic          err_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_err_unit #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_samples(frame_samples),
        .parity_mode(parity_mode), .err_en(err_en), .status_rd(status_rd), .data_rd(data_rd),
        .brk_active(brk_active), .brk_clr_en(brk_clr_en), .rx_data(rx_data),
        .rx_full(rx_full), .err_flags(err_flags), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] mk_frame(input logic [7:0] d, input logic [1:0] m,
                                                input logic flip, input logic stop,
                                                input logic [3:0] npos);
        logic [FW-1:0] b;
        logic [SW-1:0] s;
        b = '0;
        b[DW:1] = d;
        if (m == 2'd1)      b[DW+1] = (^d) ^ flip;
        else if (m == 2'd2) b[DW+1] = (~^d) ^ flip;
        else                b[DW+1] = flip;
        b[DW+2] = stop;
        for (int k = 0; k < FW; k++) begin
            s[3*k +: 3] = {3{b[k]}};
            if (k == int'(npos)) s[3*k+1] = ~b[k];
        end
        return s;
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] m, input logic flip,
                        input logic stop, input logic [3:0] npos);
        @(negedge clk);
        parity_mode   = m;
        frame_samples = mk_frame(d, m, flip, stop, npos);
        frame_valid   = 1'b1;
        @(negedge clk);
        frame_valid   = 1'b0;
    endtask

    task automatic rd_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic rd_data();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic clear_all();
        rd_status();
        rd_data();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset flags", err_flags, 4'h0);
        chk("R11 reset full", rx_full, 1'b0);
        chk("R11 reset data", rx_data, 8'h00);
        chk("R5 reset irq", err_irq, 1'b0);

        // Table: R2 R3 R4 R5 R6 R11
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][19:12], VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            chk($sformatf("R2 data vec%0d", i), rx_data, VEC[i][19:12]);
            chk($sformatf("R3/R4/R2 flags vec%0d", i), err_flags, VEC[i][3:0]);
            chk($sformatf("R5 irq vec%0d", i), err_irq, |VEC[i][3:0]);
            chk($sformatf("R11 full vec%0d", i), rx_full, 1'b1);
            clear_all();
            chk($sformatf("R6 cleared vec%0d", i), err_flags, 4'h0);
            chk($sformatf("R11 emptied vec%0d", i), rx_full, 1'b0);
        end

        // R1 overrun
        send(8'h11, 2'd0, 1'b0, 1'b1, 4'd15);
        send(8'h22, 2'd1, 1'b1, 1'b0, 4'd2);
        chk("R1 old data kept", rx_data, 8'h11);
        chk("R1 only overrun set", err_flags, 4'b0001);
        clear_all();
        chk("R1 cleared", err_flags, 4'h0);

        // R6: data read alone does nothing; only armed flags clear
        send(8'h33, 2'd0, 1'b0, 1'b1, 4'd4);
        rd_data();
        chk("R6 data read unarmed", err_flags, 4'b0010);
        chk("R11 full cleared by read", rx_full, 1'b0);
        rd_status();
        send(8'h44, 2'd0, 1'b0, 1'b0, 4'd15);
        chk("R6 new framing", err_flags, 4'b0110);
        rd_data();
        chk("R6 only seen flags cleared", err_flags, 4'b0100);
        clear_all();

        // R7: same flag re-raised between the two steps
        send(8'h55, 2'd0, 1'b0, 1'b1, 4'd5);
        rd_data();
        rd_status();
        send(8'h66, 2'd0, 1'b0, 1'b1, 4'd6);
        rd_data();
        chk("R7 event between steps survives", err_flags, 4'b0010);
        clear_all();
        chk("R7 cleared later", err_flags, 4'h0);

        // R8: protected break
        send(8'h77, 2'd1, 1'b1, 1'b1, 4'd15);
        brk_active = 1'b1;
        clear_all();
        chk("R8 flags held in break", err_flags, 4'b1000);
        chk("R8 full held in break", rx_full, 1'b1);
        brk_active = 1'b0;
        rd_data();
        chk("R8 status read in break did not arm", err_flags, 4'b1000);
        clear_all();
        chk("R8 cleared after break", err_flags, 4'h0);

        // R10: armed before break, completed after
        send(8'h88, 2'd2, 1'b1, 1'b1, 4'd15);
        rd_status();
        brk_active = 1'b1;
        rd_data();
        chk("R10 held during break", err_flags, 4'b1000);
        brk_active = 1'b0;
        rd_data();
        chk("R10 second step after break", err_flags, 4'h0);

        // R9: permissive break
        send(8'h99, 2'd1, 1'b1, 1'b1, 4'd15);
        brk_active = 1'b1;
        brk_clr_en = 1'b1;
        clear_all();
        chk("R9 cleared in break", err_flags, 4'h0);
        brk_active = 1'b0;
        brk_clr_en = 1'b0;
        @(negedge clk);
        chk("R9 stays clear after break", err_flags, 4'h0);

        // R5: enables
        send(8'hAA, 2'd0, 1'b0, 1'b0, 4'd15);
        err_en = 4'b0000;
        @(negedge clk);
        chk("R5 irq masked", err_irq, 1'b0);
        err_en = 4'b0100;
        @(negedge clk);
        chk("R5 irq framing enabled", err_irq, 1'b1);
        err_en = 4'b1011;
        @(negedge clk);
        chk("R5 irq other enables", err_irq, 1'b0);
        err_en = 4'hF;
        clear_all();
        chk("R5 irq after clear", err_irq, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule